// File: doc/BRIEF.md
# DDR serial ADC lane deserializer

This block turns several single-ended serial converter lanes into parallel sample words. A bit clock toggles once per bit, and every lane is sampled on both of its edges. Per lane, one shift chain takes the bits seen on the rising edge and a second chain takes those seen on the falling edge. A frame clock marks word boundaries. On each frame-clock rising edge the two chains are interleaved into a right-aligned word of 8, 10, 12 or 14 bits. That word then passes through two frame-clock registers.

Lanes are grouped in adjacent pairs. Each pair has its own select input, which picks one of the two lanes for that pair's shared output bus. Each bus also has an output clock whose rising edge falls in the middle of the word's hold time.

A common valid strobe blanks the outputs after reset, after a change of resolution and after a timing resynchronisation. A timing resynchronisation also clears the words.

Top module: `ddr_lane_deser`

## Requirements
- R1: The number of lanes `NUM_LANES` is a parameter (4 or 8, default 8). Each lane carries an independent channel, and the data of one lane never appears in the word of another.
- R2: A frame of N bits begins, most significant bit first, on the bit-clock falling edge that coincides with a frame-clock rising edge. Falling-edge samples land in the odd bit positions of the word and rising-edge samples in the even positions. The last bit of a frame (bit 0) is sampled on the last rising edge before the next frame-clock rising edge.
- R3: `res_sel` sets the resolution N = 8 + 2*res_sel: 0 gives 8 bits, 1 gives 10, 2 gives 12 and 3 gives 14. The bench drives a frame of N bits accordingly.
- R4: The word is right-aligned in 14 bits, and bits N through 13 are zero.
- R5: The word presented after frame-clock rising edge e is the frame that began at edge e-2. It stays unchanged until edge e+1.
- R6: `pair_sel[p]`, sampled on the frame-clock rising edge, routes lane 2p to bus p when it is 0 and lane 2p+1 when it is 1.
- R7: `pair_clk[p]` is the inverse of the frame clock, so it rises in the middle of each word's hold time.
- R8: `bus_valid` is high on every frame once settled. When the frame clock samples a `res_sel` that differs from the previous sample, `bus_valid` is low after that edge and after the next three edges, and high after the fourth. The first two frames at the new resolution are therefore dropped.
- R9: A high `resync` sampled on a frame-clock rising edge clears every bus word to zero after that edge. It also starts the same blanking sequence as R8.
- R10: While `rst_n` is low, every bus word is zero and `bus_valid` is low. `bus_valid` also stays low after the first two frame-clock edges that follow the release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each clock domain |
| dco | input | 1 | Bit clock; lanes are sampled on both edges |
| fco | input | 1 | Frame clock; its rising edge closes a word |
| lane_in | input | NUM_LANES | Serial lane data |
| res_sel | input | 2 | Resolution code, N = 8 + 2*res_sel |
| pair_sel | input | NUM_LANES/2 | Per-pair lane select (0 = even lane, 1 = odd lane) |
| resync | input | 1 | Timing resynchronisation: clears words and restarts blanking |
| bus_word | output | NUM_LANES/2 x 14 | Multiplexed parallel word per pair |
| pair_clk | output | NUM_LANES/2 | Output clock per bus, the inverse of fco |
| bus_valid | output | 1 | High when the bus words hold settled frames |

## Verification
On every frame-clock edge, the assertions check three things. The upper bits above the active resolution are zero whenever the strobe is high. A resolution change or a resync holds the strobe low for three samples. A resync empties every bus word.

Some behaviour only the bench's scenarios can show. These are the bit ordering across the two edges, the two-frame latency, the lane routing per pair and the word holding steady through the middle of the frame. The bench sweeps all four resolutions against computed frames to show them.

// File: rtl/ddr_deser_pkg.sv
package ddr_deser_pkg;
  localparam int CHAIN_DEPTH = 7;
  localparam int WORD_W      = 2 * CHAIN_DEPTH;
  localparam int MIN_PAIRS   = 4;

  typedef logic [WORD_W-1:0] word_t;

  // Interleave the rising-edge chain (even bits) and the falling-edge chain
  // (odd bits); keep only the pairs that belong to the active resolution.
  function automatic word_t merge_chains(input logic [CHAIN_DEPTH-1:0] rise_bits,
                                         input logic [CHAIN_DEPTH-1:0] fall_bits,
                                         input logic [1:0]             res_code);
    word_t w;
    int    pairs;
    w     = '0;
    pairs = MIN_PAIRS + int'(res_code);
    for (int k = 0; k < CHAIN_DEPTH; k++) begin
      if (k < pairs) begin
        w[2*k]   = rise_bits[k];
        w[2*k+1] = fall_bits[k];
      end
    end
    return w;
  endfunction
endpackage

// File: rtl/ddr_rst_sync.sv
module ddr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] pipe_q;
  logic [1:0] pipe_d;

  always_comb pipe_d = {pipe_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= pipe_d;
  end

  assign rst_sync_n = pipe_q[1];
endmodule

// File: rtl/ddr_lane_capture.sv
module ddr_lane_capture #(
  parameter int DEPTH = 7
) (
  input  logic             dco,
  input  logic             rst_n,
  input  logic             din,
  output logic [DEPTH-1:0] rise_bits,
  output logic [DEPTH-1:0] fall_bits
);
  logic [DEPTH-1:0] rise_q, rise_d;
  logic [DEPTH-1:0] fall_q, fall_d;

  always_comb begin
    rise_d = {rise_q[DEPTH-2:0], din};
    fall_d = {fall_q[DEPTH-2:0], din};
  end

  always_ff @(posedge dco or negedge rst_n) begin
    if (!rst_n) rise_q <= '0;
    else        rise_q <= rise_d;
  end

  always_ff @(negedge dco or negedge rst_n) begin
    if (!rst_n) fall_q <= '0;
    else        fall_q <= fall_d;
  end

  assign rise_bits = rise_q;
  assign fall_bits = fall_q;
endmodule

// File: rtl/ddr_frame_gate.sv
module ddr_frame_gate #(
  parameter int BLANK_FRAMES = 2
) (
  input  logic       fco,
  input  logic       rst_n,
  input  logic [1:0] res_sel,
  input  logic       resync,
  output logic       restart,
  output logic       valid
);
  localparam int             HOLD    = BLANK_FRAMES + 1;
  localparam int             CW      = $clog2(HOLD + 1);
  localparam logic [CW-1:0]  CNT_TOP = CW'(HOLD);

  logic [1:0]    res_q;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          valid_q, valid_d;

  always_comb begin
    restart = (res_sel != res_q) || resync;
    cnt_d   = cnt_q;
    if (restart)               cnt_d = '0;
    else if (cnt_q != CNT_TOP) cnt_d = cnt_q + 1'b1;
    valid_d = !restart && (cnt_q == CNT_TOP);
  end

  always_ff @(posedge fco or negedge rst_n) begin
    if (!rst_n) begin
      res_q   <= '0;
      cnt_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      res_q   <= res_sel;
      cnt_q   <= cnt_d;
      valid_q <= valid_d;
    end
  end

  assign valid = valid_q;
endmodule

// File: rtl/ddr_lane_deser.sv
module ddr_lane_deser #(
  parameter int  NUM_LANES    = 8,
  parameter int  BLANK_FRAMES = 2,
  localparam int NUM_PAIRS    = NUM_LANES / 2,
  localparam int WORD_W       = ddr_deser_pkg::WORD_W
) (
  input  logic                             rst_n,
  input  logic                             dco,
  input  logic                             fco,
  input  logic [NUM_LANES-1:0]             lane_in,
  input  logic [1:0]                       res_sel,
  input  logic [NUM_PAIRS-1:0]             pair_sel,
  input  logic                             resync,
  output logic [NUM_PAIRS-1:0][WORD_W-1:0] bus_word,
  output logic [NUM_PAIRS-1:0]             pair_clk,
  output logic                             bus_valid
);
  import ddr_deser_pkg::*;

  logic dco_rst_n;
  logic fco_rst_n;
  logic restart;

  logic [NUM_LANES-1:0][CHAIN_DEPTH-1:0] rise_bits;
  logic [NUM_LANES-1:0][CHAIN_DEPTH-1:0] fall_bits;
  logic [NUM_LANES-1:0][WORD_W-1:0]      snap_q, snap_d;
  logic [NUM_PAIRS-1:0][WORD_W-1:0]      bus_q, bus_d;

  ddr_rst_sync u_dco_rst (.clk(dco), .rst_n(rst_n), .rst_sync_n(dco_rst_n));
  ddr_rst_sync u_fco_rst (.clk(fco), .rst_n(rst_n), .rst_sync_n(fco_rst_n));

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    ddr_lane_capture #(.DEPTH(CHAIN_DEPTH)) u_cap (
      .dco       (dco),
      .rst_n     (dco_rst_n),
      .din       (lane_in[l]),
      .rise_bits (rise_bits[l]),
      .fall_bits (fall_bits[l])
    );
    always_comb snap_d[l] = resync ? '0 : merge_chains(rise_bits[l], fall_bits[l], res_sel);
  end

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    always_comb begin
      if (resync)           bus_d[p] = '0;
      else if (pair_sel[p]) bus_d[p] = snap_q[2*p+1];
      else                  bus_d[p] = snap_q[2*p];
    end
    assign pair_clk[p] = ~fco;
  end

  ddr_frame_gate #(.BLANK_FRAMES(BLANK_FRAMES)) u_gate (
    .fco     (fco),
    .rst_n   (fco_rst_n),
    .res_sel (res_sel),
    .resync  (resync),
    .restart (restart),
    .valid   (bus_valid)
  );

  always_ff @(posedge fco or negedge fco_rst_n) begin
    if (!fco_rst_n) begin
      snap_q <= '0;
      bus_q  <= '0;
    end else begin
      snap_q <= snap_d;
      bus_q  <= bus_d;
    end
  end

  assign bus_word = bus_q;
endmodule

// File: rtl/ddr_lane_deser_chk.sv
module ddr_lane_deser_chk #(
  parameter int NP = 4,
  parameter int W  = 14
) (
  input logic                 fco,
  input logic                 rst_n,
  input logic [1:0]           res_sel,
  input logic                 resync,
  input logic [NP-1:0][W-1:0] bus_word,
  input logic                 bus_valid
);
  assert_resync_clears_R9: assert property (@(posedge fco) disable iff (!rst_n)
    resync |=> (bus_word == '0));

  assert_resync_blank_R9: assert property (@(posedge fco) disable iff (!rst_n)
    resync |=> !bus_valid ##1 !bus_valid ##1 !bus_valid);

  assert_res_change_blank_R8: assert property (@(posedge fco) disable iff (!rst_n)
    (res_sel != $past(res_sel)) |=> !bus_valid ##1 !bus_valid ##1 !bus_valid);

  for (genvar p = 0; p < NP; p++) begin : g_bus
    assert_upper_zero_R4: assert property (@(posedge fco) disable iff (!rst_n)
      bus_valid |-> ((bus_word[p] >> (8 + 2 * int'($past(res_sel)))) == '0));
  end
endmodule

bind ddr_lane_deser ddr_lane_deser_chk #(.NP(NUM_PAIRS), .W(ddr_deser_pkg::WORD_W)) u_chk (
  .fco       (fco),
  .rst_n     (rst_n),
  .res_sel   (res_sel),
  .resync    (resync),
  .bus_word  (bus_word),
  .bus_valid (bus_valid)
);

// File: tb/ddr_lane_deser_test.sv
module ddr_lane_deser_test;
  localparam int LANES  = 8;
  localparam int PAIRS  = LANES / 2;
  localparam int W      = 14;
  localparam int FRAMES = 67;
  localparam int RS1    = 8;
  localparam int RS2    = 60;

  logic                       rst_n, dco, fco, resync;
  logic [LANES-1:0]           lane_in;
  logic [1:0]                 res_sel;
  logic [PAIRS-1:0]           pair_sel;
  logic [PAIRS-1:0][W-1:0]    bus_word;
  logic [PAIRS-1:0]           pair_clk;
  logic                       bus_valid;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  ddr_lane_deser #(.NUM_LANES(LANES)) uut (
    .rst_n(rst_n), .dco(dco), .fco(fco), .lane_in(lane_in), .res_sel(res_sel),
    .pair_sel(pair_sel), .resync(resync), .bus_word(bus_word), .pair_clk(pair_clk),
    .bus_valid(bus_valid)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int res_of(input int f);
    if (f < 20) return 0;
    if (f < 32) return 1;
    if (f < 44) return 2;
    if (f < 56) return 3;
    return 0;
  endfunction

  function automatic logic [W-1:0] word_of(input int f, input int l, input int n);
    int mask;
    mask = (1 << n) - 1;
    case (f % 9)
      0:       return W'(mask);
      1:       return '0;
      2:       return W'(32'h2AAA & mask);
      default: return W'(((f * 73 + l * 41 + 11) * 2749) & mask);
    endcase
  endfunction

  logic [W-1:0] exp_w [4][LANES];

  initial begin
    logic [PAIRS-1:0][W-1:0] held;
    logic [PAIRS-1:0]        ps;
    int  chg, res_prev, n, lane;
    bit  track, vexp;
    rst_n = 0; dco = 1; fco = 0; resync = 0; lane_in = '0; res_sel = '0; pair_sel = '0;
    chg = -100; res_prev = 0; track = 0; held = '0;
    for (int f = 0; f < FRAMES; f++) begin
      n  = 8 + 2 * res_of(f);
      ps = PAIRS'(f * 5 + 3);
      for (int l = 0; l < LANES; l++) exp_w[f % 4][l] = word_of(f, l, n);
      for (int i = 0; i < n; i++) begin
        for (int l = 0; l < LANES; l++) lane_in[l] = exp_w[f % 4][l][n-1-i];
        if (i == 0) begin
          res_sel  = 2'(res_of(f));
          pair_sel = ps;
          resync   = (f == RS1) || (f == RS2);
          if (f == 3) rst_n = 1;
        end
        #2.5;
        if (i % 2 == 0) begin
          dco = 0;
          if (i == 0) fco = 1;
        end else begin
          dco = 1;
        end
        if (i == n / 2) fco = 0;
        #2.5;
        if (i == 0) begin
          // reset and early release (R10)
          if (f < 3) begin
            check("R10 valid in reset", 32'(bus_valid), 0);
            for (int p = 0; p < PAIRS; p++) check("R10 word in reset", 32'(bus_word[p]), 0);
          end
          if (f == 3 || f == 4) check("R10 valid after release", 32'(bus_valid), 0);
          if (f == RS1) track = 1;
          if (f >= 5 && (resync || res_of(f) != res_prev)) chg = f;
          res_prev = res_of(f);
          if (resync)
            for (int p = 0; p < PAIRS; p++) check("R9 resync clears word", 32'(bus_word[p]), 0);
          if (track) begin
            vexp = (f - chg) >= 4;
            check("R8 R9 valid strobe", 32'(bus_valid), 32'(vexp));
          end
          if (bus_valid && f >= 5)
            for (int p = 0; p < PAIRS; p++) begin
              lane = ps[p] ? 2 * p + 1 : 2 * p;
              check("R1 R2 R3 R4 R6 bus data", 32'(bus_word[p]), 32'(exp_w[(f - 2) % 4][lane]));
            end
          check("R7 pair clock low", 32'(pair_clk), 0);
          held = bus_word;
        end
        if (i == n / 2) begin
          check("R7 pair clock high", 32'(pair_clk), 32'({PAIRS{1'b1}}));
          if (f >= 3) check("R5 word held mid-frame", 32'(bus_word != held), 0);
        end
      end
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule